// File: doc/BRIEF.md
# Serial Tuner Control Word Receiver

This block accepts control words for a tuner frequency synthesizer over a three-wire bus made of an enable line, a serial clock and a serial data line. It moves all three lines into the system clock domain, detects serial clock falling edges there and shifts one data bit on each such edge while enable is high. Frames are committed in stages. Once four bits have arrived, the band-switch group is applied. Once nineteen have arrived, the divider group is applied. Once twenty-seven have arrived, the mode group is applied.

A frame that stops early therefore commits only the groups it has completed. The held values drive four band-switch enables and give the surrounding synthesizer logic the main count, swallow count, charge-pump current choice, test-mode code, reference-ratio code and tuning-amplifier disable. A synchronous reset loads power-on defaults.

Top module: `synth_ctl_rx`

## Requirements
- R1: A bit is taken only on a falling edge of the serial clock, sampled with the data level present at that edge, and only while enable is high. Rising edges shift nothing, and edges while enable is low shift nothing.
- R2: The first four bits of a frame go to band_on[3], band_on[2], band_on[1] and band_on[0] in that order and are applied after the 4th falling edge. A value of 1 switches that band output on.
- R3: Bits 5 to 14 form main_cnt, most significant bit first. Bits 15 to 19 form swallow_cnt, most significant bit first. Both are applied together after the 19th falling edge.
- R4: If enable falls after 4 but before 19 edges, only band_on changes. If it falls before 4 edges, no output changes.
- R5: Bits 20 to 27 are, in order: an ignored bit, cp_high, test_mode[2], test_mode[1], test_mode[0], ref_sel[1], ref_sel[0] and tune_amp_off. They are applied after the 27th edge. A frame of 19 to 26 edges leaves them unchanged.
- R6: Falling edges after the 27th within one enable window change nothing.
- R7: The bit count restarts at bit 1 on every enable window, so a frame after an over-long frame decodes correctly.
- R8: After reset the outputs are as follows. band_on is 0, main_cnt is 0 and swallow_cnt is 0. cp_high is 1, which selects the high current. test_mode is 3'b010, which puts the pump in high impedance. ref_sel is 2'b10, which selects the 1/640 ratio. tune_amp_off is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bus clock, asynchronous |
| ser_data | input | 1 | Serial bus data, asynchronous |
| ser_en | input | 1 | Serial bus enable, high during a frame |
| band_on | output | BAND_W | Band-switch enables, 1 = on |
| main_cnt | output | MAIN_W | Latched main counter ratio |
| swallow_cnt | output | SWAL_W | Latched swallow counter ratio |
| cp_high | output | 1 | Charge-pump high current select |
| test_mode | output | 3 | Test-mode code |
| ref_sel | output | 2 | Reference divider ratio code |
| tune_amp_off | output | 1 | Tuning amplifier disable |

## Verification
The bench builds the block with its default parameters: four band bits, a ten-bit main count, a five-bit swallow count and two synchronizer stages. These defaults place the group boundaries at edges 4, 19 and 27, so frames of 2, 10, 23, 27 and 30 bits each stop short of, straddle or overrun a distinct boundary. Each serial half period spans several system clocks, which lets the bench change data while the serial clock is high and so tell falling-edge sampling apart from rising-edge sampling.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

  // Width of the trailing mode group in a full frame.
  localparam int MODE_W = 8;

  typedef struct packed {
    logic       cp_high;
    logic [2:0] test_mode;
    logic [1:0] ref_sel;
    logic       tune_off;
  } mode_t;

  // Power-on state: high pump current, pump tri-stated, 1/640 ratio, amp off.
  localparam mode_t MODE_RESET = '{cp_high: 1'b1, test_mode: 3'b010,
                                   ref_sel: 2'b10, tune_off: 1'b1};

  // Decode the mode group without its leading ignored bit.
  function automatic mode_t unpack_mode(input logic [MODE_W-2:0] b);
    mode_t m;
    m.cp_high   = b[6];
    m.test_mode = b[5:3];
    m.ref_sel   = b[2:1];
    m.tune_off  = b[0];
    return m;
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk_i,
  input  logic ser_data_i,
  input  logic ser_en_i,
  output logic fall_o,
  output logic data_o,
  output logic en_o
);
  localparam int W = 3;

  logic [W-1:0] pipe [STAGES];
  logic         sclk_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= {ser_en_i, ser_data_i, ser_clk_i};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= pipe[STAGES-1][0];
  end

  assign fall_o = sclk_prev & ~pipe[STAGES-1][0];
  assign data_o = pipe[STAGES-1][1];
  assign en_o   = pipe[STAGES-1][2];

endmodule

// File: rtl/sctl_frame.sv
module sctl_frame #(
  parameter int BAND_END = 4,
  parameter int DIV_END  = 19,
  parameter int FULL_END = 27,
  parameter int SH_W     = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fall_i,
  input  logic            data_i,
  input  logic            en_i,
  output logic [SH_W-1:0] shreg_o,
  output logic            band_stb_o,
  output logic            div_stb_o,
  output logic            mode_stb_o
);
  localparam int CNT_W = $clog2(FULL_END + 1);
  localparam logic [CNT_W-1:0] BAND_LAST = CNT_W'(BAND_END - 1);
  localparam logic [CNT_W-1:0] DIV_LAST  = CNT_W'(DIV_END - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_END - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FULL_END);

  logic [CNT_W-1:0] cnt;
  logic             take;

  assign take = en_i & fall_i & (cnt < CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      shreg_o    <= '0;
      band_stb_o <= 1'b0;
      div_stb_o  <= 1'b0;
      mode_stb_o <= 1'b0;
    end else begin
      band_stb_o <= take & (cnt == BAND_LAST);
      div_stb_o  <= take & (cnt == DIV_LAST);
      mode_stb_o <= take & (cnt == FULL_LAST);
      if (!en_i) begin
        cnt <= '0;
      end else if (take) begin
        cnt     <= cnt + 1'b1;
        shreg_o <= {shreg_o[SH_W-2:0], data_i};
      end
    end
  end

  // R7: the count is back at zero after any cycle with enable low
  assert_cnt_restart_R7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> cnt == '0);

  // R6: once saturated the count holds until the window closes
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX || cnt == '0));

  // R1: nothing shifts without a falling edge inside an enable window
  assert_shift_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !(fall_i && en_i) |=> $stable(shreg_o));

endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import synth_ctl_pkg::*;
#(
  parameter int BAND_W = 4,
  parameter int MAIN_W = 10,
  parameter int SWAL_W = 5,
  parameter int SH_W   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SH_W-1:0]   shreg_i,
  input  logic              band_stb_i,
  input  logic              div_stb_i,
  input  logic              mode_stb_i,
  output logic [BAND_W-1:0] band_o,
  output logic [MAIN_W-1:0] main_o,
  output logic [SWAL_W-1:0] swal_o,
  output mode_t             mode_o
);
  localparam int DIV_W = MAIN_W + SWAL_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      band_o <= '0;
      main_o <= '0;
      swal_o <= '0;
      mode_o <= MODE_RESET;
    end else begin
      if (band_stb_i) band_o <= shreg_i[BAND_W-1:0];
      if (div_stb_i) begin
        main_o <= shreg_i[DIV_W-1:SWAL_W];
        swal_o <= shreg_i[SWAL_W-1:0];
      end
      if (mode_stb_i) mode_o <= unpack_mode(shreg_i[MODE_W-2:0]);
    end
  end

  // R4: group strobes come from distinct edge counts, never together
  assert_stb_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({band_stb_i, div_stb_i, mode_stb_i}));

  // R2: band enables move only on the band strobe
  assert_band_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !band_stb_i |=> $stable(band_o));

  // R3: divider counts move only on the divider strobe
  assert_div_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !div_stb_i |=> ($stable(main_o) && $stable(swal_o)));

  // R5: mode group moves only on the mode strobe
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !mode_stb_i |=> $stable(mode_o));

endmodule

// File: rtl/synth_ctl_rx.sv
module synth_ctl_rx
  import synth_ctl_pkg::*;
#(
  parameter int BAND_W      = 4,
  parameter int MAIN_W      = 10,
  parameter int SWAL_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  output logic [BAND_W-1:0] band_on,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swallow_cnt,
  output logic              cp_high,
  output logic [2:0]        test_mode,
  output logic [1:0]        ref_sel,
  output logic              tune_amp_off
);
  localparam int DIV_W    = MAIN_W + SWAL_W;
  localparam int BAND_END = BAND_W;
  localparam int DIV_END  = BAND_W + DIV_W;
  localparam int FULL_END = DIV_END + MODE_W;
  localparam int SH_A     = (BAND_W > DIV_W) ? BAND_W : DIV_W;
  localparam int SH_W     = (SH_A > MODE_W) ? SH_A : MODE_W;

  logic            fall_s, data_s, en_s;
  logic [SH_W-1:0] shreg;
  logic            band_stb, div_stb, mode_stb;
  mode_t           mode;

  sctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_en_i(ser_en),
    .fall_o(fall_s), .data_o(data_s), .en_o(en_s)
  );

  sctl_frame #(
    .BAND_END(BAND_END), .DIV_END(DIV_END), .FULL_END(FULL_END), .SH_W(SH_W)
  ) u_frame (
    .clk(clk), .rst(rst),
    .fall_i(fall_s), .data_i(data_s), .en_i(en_s),
    .shreg_o(shreg),
    .band_stb_o(band_stb), .div_stb_o(div_stb), .mode_stb_o(mode_stb)
  );

  sctl_regs #(
    .BAND_W(BAND_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .SH_W(SH_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .shreg_i(shreg),
    .band_stb_i(band_stb), .div_stb_i(div_stb), .mode_stb_i(mode_stb),
    .band_o(band_on), .main_o(main_cnt), .swal_o(swallow_cnt), .mode_o(mode)
  );

  assign cp_high      = mode.cp_high;
  assign test_mode    = mode.test_mode;
  assign ref_sel      = mode.ref_sel;
  assign tune_amp_off = mode.tune_off;

endmodule

// File: tb/synth_ctl_rx_tb.sv
module synth_ctl_rx_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [3:0] band_on;
  logic [9:0] main_cnt;
  logic [4:0] swallow_cnt;
  logic       cp_high;
  logic [2:0] test_mode;
  logic [1:0] ref_sel;
  logic       tune_amp_off;

  always #10 clk = ~clk;

  synth_ctl_rx u_dut (
    .clk(clk), .rst(rst),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .band_on(band_on), .main_cnt(main_cnt), .swallow_cnt(swallow_cnt),
    .cp_high(cp_high), .test_mode(test_mode), .ref_sel(ref_sel),
    .tune_amp_off(tune_amp_off)
  );

  typedef struct {
    logic [3:0] band;
    logic [9:0] m;
    logic [4:0] s;
    logic       cp;
    logic [2:0] t;
    logic [1:0] rs;
    logic       os;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t model;
  logic [14:0] mreg;
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Driver: sends a frame, advances the expected model from the requirements
  task automatic send(input logic [31:0] word, input int n, input string tag);
    exp_t e;
    ser_en = 1'b1;
    w(4);
    for (int i = 0; i < n; i++) begin
      int k;
      k = i + 1;
      ser_clk = 1'b1;
      w(4);
      ser_data = word[n-1-i];   // data changes while clock is high (R1)
      w(4);
      ser_clk = 1'b0;
      w(4);
      if (k <= 27) begin
        mreg = {mreg[13:0], word[n-1-i]};
        if (k == 4)  model.band = mreg[3:0];
        if (k == 19) begin model.m = mreg[14:5]; model.s = mreg[4:0]; end
        if (k == 27) begin
          model.cp = mreg[6]; model.t = mreg[5:3];
          model.rs = mreg[2:1]; model.os = mreg[0];
        end
      end
    end
    w(2);
    ser_en = 1'b0;
    w(8);
    e = model;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      chk(e.tag, "band_on",      int'(band_on),      int'(e.band));
      chk(e.tag, "main_cnt",     int'(main_cnt),     int'(e.m));
      chk(e.tag, "swallow_cnt",  int'(swallow_cnt),  int'(e.s));
      chk(e.tag, "cp_high",      int'(cp_high),      int'(e.cp));
      chk(e.tag, "test_mode",    int'(test_mode),    int'(e.t));
      chk(e.tag, "ref_sel",      int'(ref_sel),      int'(e.rs));
      chk(e.tag, "tune_amp_off", int'(tune_amp_off), int'(e.os));
      if (exp_q.size() == 0) done = 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_t e;
    model = '{band: 4'h0, m: 10'h0, s: 5'h0, cp: 1'b1, t: 3'b010,
              rs: 2'b10, os: 1'b1, tag: "R8"};
    mreg = '0;
    w(5);
    rst = 1'b0;
    w(4);
    e = model; e.tag = "R8_reset";
    exp_q.push_back(e);
    w(2);

    // R2 R3 R5: full frame
    mreg = '0;
    send({5'd0, 4'b1010, 10'h2A5, 5'h13, 8'hAA}, 27, "R2_R3_R5_full");
    // R4: stops after band group
    send({22'd0, 10'b0110_110011}, 10, "R4_band_only");
    // R4: stops before band group completes
    send({30'd0, 2'b11}, 2, "R4_short");
    // R5: divider committed, mode untouched
    send({9'd0, 4'b0001, 10'h3FF, 5'h00, 4'b1111}, 23, "R5_no_mode");
    // R6: three surplus edges
    send({2'd0, 4'b1111, 10'h020, 5'h1F, 8'h5B, 3'b101}, 30, "R6_overrun");

    // R1: clock toggles with enable low shift nothing
    for (int i = 0; i < 30; i++) begin
      ser_clk = 1'b1; w(3);
      ser_data = ~ser_data; w(3);
      ser_clk = 1'b0; w(3);
    end
    w(8);
    e = model; e.tag = "R1_en_low";
    exp_q.push_back(e);

    // R7: new frame after an overrun decodes from bit 1
    send({5'd0, 4'b0000, 10'h155, 5'h0A, 8'h00}, 27, "R7_restart");

    wait (done);
    w(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule